// File: doc/BRIEF.md
# Quad-Precision Floating-Point Min/Max Unit

This unit selects the smaller or the larger of two IEEE binary128 operands and returns it one clock after the request. The operand format comes from the `EXP_W` and `MAN_W` parameters. The defaults give a 128-bit value: 1 sign bit at the top, then 15 exponent bits, then 112 fraction bits. Smaller values of the two parameters give a narrow copy of the same logic.

Two mode inputs set the behaviour. One chooses between minimum and maximum. The other chooses how NaN inputs are handled:
- **Number-preferring:** if one input is a NaN, the other input is returned.
- **NaN-propagating:** if either input is a NaN, the canonical NaN is returned.

Negative zero orders below positive zero. A signaling NaN on either input raises the invalid flag, even when the result is an ordinary number. The unit does no rounding and no arithmetic.

A request is a cycle with `valid_i` high. In the next cycle `valid_o` is high and `result_o` and `invalid_o` hold that request's answer. Between requests the two outputs keep their last value.

Top module: `fp_minmax_q`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `result_o` and `invalid_o` are all zero.
- R2: `valid_o` equals `valid_i` delayed by one cycle. `result_o` and `invalid_o` change only in the cycle after a cycle with `valid_i` high, and hold their value otherwise.
- R3: With `sel_max_i`=0 and neither input a NaN, `result_o` is the numerically smaller operand. Its bits are copied exactly, including sign and fraction.
- R4: With `sel_max_i`=1 and neither input a NaN, `result_o` is the numerically larger operand, bits copied exactly.
- R5: Negative zero (sign 1, all other bits 0) is ordered below positive zero (all bits 0). This holds for both minimum and maximum.
- R6: With `nan_prop_i`=0, if exactly one input is a NaN, `result_o` is the other input. A NaN has exponent all ones and a non-zero fraction.
- R7: With `nan_prop_i`=0, if both inputs are NaN, `result_o` is the canonical NaN. The canonical NaN has sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0.
- R8: With `nan_prop_i`=1, if either input is a NaN, `result_o` is the canonical NaN.
- R9: `invalid_o` is 1 exactly when at least one input is a signaling NaN, meaning a NaN whose fraction MSB is 0. This holds whatever value is returned. Quiet NaNs alone leave `invalid_o` at 0.
- R10: The mode encodings are:
  - `sel_max_i`: 0 selects minimum, 1 selects maximum.
  - `nan_prop_i`: 0 selects number-preferring, 1 selects NaN-propagating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| sel_max_i | input | 1 | 1 selects maximum, 0 selects minimum |
| nan_prop_i | input | 1 | 1 selects NaN-propagating, 0 selects number-preferring |
| op_a_i | input | 1+EXP_W+MAN_W | First operand |
| op_b_i | input | 1+EXP_W+MAN_W | Second operand |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 1+EXP_W+MAN_W | Selected value or canonical NaN |
| invalid_o | output | 1 | Signaling-NaN flag |

## Verification
A 6-bit instance (3 exponent bits, 2 fraction bits) is driven with every operand pair in all four modes. Expected values come from a signed integer ordering key that the bench computes for each value. This sweep exposes several kinds of error:
- A comparator that treats the sign as an ordinary magnitude bit reverses the order of negative pairs.
- A comparator that ignores the sign of zero returns +0 where -0 is expected.
- A mix-up of the two NaN policies returns the number where the canonical NaN is expected, or the reverse.
- A flag driven by the NaN class of the result, rather than of the inputs, is lost when a number is returned next to a signaling NaN.

Directed binary128 vectors check that the canonical NaN and the exact payload pass-through are right at full width. Idle cycles check that the outputs hold between requests.

// File: rtl/fp_minmax_pkg.sv
package fp_minmax_pkg;
  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } fp_class_t;
endpackage

// File: rtl/fp_minmax_class.sv
module fp_minmax_class
  import fp_minmax_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 112,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_i,
  output fp_class_t    cls_o
);
  logic exp_ones, frac_nz;
  assign exp_ones = &op_i[W-2 -: EXP_W];
  assign frac_nz  = |op_i[MAN_W-1:0];
  assign cls_o.is_nan  = exp_ones & frac_nz;
  // quiet bit is the fraction MSB
  assign cls_o.is_snan = exp_ones & frac_nz & ~op_i[MAN_W-1];
endmodule

// File: rtl/fp_minmax_order.sv
module fp_minmax_order #(
  parameter int W = 128
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         a_lt_b_o
);
  logic sa, sb;
  logic [W-2:0] ma, mb;
  assign sa = a_i[W-1];
  assign sb = b_i[W-1];
  assign ma = a_i[W-2:0];
  assign mb = b_i[W-2:0];
  // sign-magnitude order; differing signs decide alone, so -0 < +0
  always_comb begin
    if (sa != sb)  a_lt_b_o = sa;
    else if (sa)   a_lt_b_o = (ma > mb);
    else           a_lt_b_o = (ma < mb);
  end
endmodule

// File: rtl/fp_minmax_q.sv
module fp_minmax_q
  import fp_minmax_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 112,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sel_max_i,
  input  logic         nan_prop_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         invalid_o
);
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0] ops [2];
  fp_class_t    cls [2];
  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_class
    fp_minmax_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
      .op_i  (ops[g]),
      .cls_o (cls[g])
    );
  end

  logic a_lt_b;
  fp_minmax_order #(.W(W)) u_order (
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .a_lt_b_o (a_lt_b)
  );

  logic         any_nan, both_nan, inv_d;
  logic [W-1:0] res_d;
  assign any_nan  = cls[0].is_nan | cls[1].is_nan;
  assign both_nan = cls[0].is_nan & cls[1].is_nan;
  assign inv_d    = cls[0].is_snan | cls[1].is_snan;

  always_comb begin
    if (nan_prop_i ? any_nan : both_nan) res_d = CANON_NAN;
    else if (cls[0].is_nan)              res_d = op_b_i;
    else if (cls[1].is_nan)              res_d = op_a_i;
    else if (sel_max_i)                  res_d = a_lt_b ? op_b_i : op_a_i;
    else                                 res_d = a_lt_b ? op_a_i : op_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        invalid_o <= inv_d;
      end
    end
  end
endmodule

// File: rtl/fp_minmax_q_chk.sv
module fp_minmax_q_chk #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 112,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         nan_prop_i,
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] op_b_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         invalid_o
);
  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_nan, b_nan, a_sn, b_sn;
  assign a_nan = (&op_a_i[W-2 -: EXP_W]) && (|op_a_i[MAN_W-1:0]);
  assign b_nan = (&op_b_i[W-2 -: EXP_W]) && (|op_b_i[MAN_W-1:0]);
  assign a_sn  = a_nan && !op_a_i[MAN_W-1];
  assign b_sn  = b_nan && !op_b_i[MAN_W-1];

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> (!valid_o && result_o == '0 && !invalid_o));

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o);

  // R2
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> (!valid_o && $stable(result_o) && $stable(invalid_o)));

  // R8
  prop_canon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && nan_prop_i && (a_nan || b_nan)) |=> result_o == CANON);

  // R6
  num_pref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !nan_prop_i && a_nan && !b_nan) |=> result_o == $past(op_b_i));

  // R9
  invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (invalid_o == ($past(a_sn) || $past(b_sn))));

  // R3
  pick_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (result_o == $past(op_a_i) || result_o == $past(op_b_i) || result_o == CANON));
endmodule

bind fp_minmax_q fp_minmax_q_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .nan_prop_i (nan_prop_i),
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .invalid_o  (invalid_o)
);

// File: tb/fp_minmax_q_tb.sv
`timescale 1ns/1ps
module fp_minmax_q_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // small instance: 3 exponent bits, 2 fraction bits
  logic       s_valid = 0, s_max = 0, s_prop = 0;
  logic [5:0] s_a = '0, s_b = '0;
  logic       s_vo, s_inv;
  logic [5:0] s_res;

  fp_minmax_q #(.EXP_W(3), .MAN_W(2)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(s_valid), .sel_max_i(s_max),
    .nan_prop_i(s_prop), .op_a_i(s_a), .op_b_i(s_b), .valid_o(s_vo),
    .result_o(s_res), .invalid_o(s_inv)
  );

  // full binary128 instance
  logic         q_valid = 0, q_max = 0, q_prop = 0;
  logic [127:0] q_a = '0, q_b = '0;
  logic         q_vo, q_inv;
  logic [127:0] q_res;

  fp_minmax_q u_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(q_valid), .sel_max_i(q_max),
    .nan_prop_i(q_prop), .op_a_i(q_a), .op_b_i(q_b), .valid_o(q_vo),
    .result_o(q_res), .invalid_o(q_inv)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int order_key(input logic [5:0] v);
    int mag;
    mag = int'(v[4:0]);
    return v[5] ? -(2 * mag + 1) : (2 * mag + 1);
  endfunction

  function automatic bit s_is_nan(input logic [5:0] v);
    return (v[4:2] == 3'b111) && (v[1:0] != 2'b00);
  endfunction

  localparam logic [5:0]   S_CANON = 6'b011110;
  localparam logic [127:0] Q_CANON = {16'h7fff, 1'b1, 111'b0};
  localparam logic [127:0] Q_ONE   = {16'h3fff, 112'b0};
  localparam logic [127:0] Q_TWO_N = {16'hc000, 112'b0};
  localparam logic [127:0] Q_NZERO = {1'b1, 127'b0};
  localparam logic [127:0] Q_SNAN  = {16'h7fff, 111'b0, 1'b1};
  localparam logic [127:0] Q_QNANP = {16'h7fff, 1'b1, 110'b0, 1'b1};
  localparam logic [127:0] Q_ODD   = {16'h4abc, 112'h123456789abcdef0fedcba987654};

  task automatic q_run(input logic [127:0] a, input logic [127:0] b, input logic mx, input logic pr,
                       input logic [127:0] exp_r, input logic exp_i, input string req);
    @(negedge clk_i);
    q_a = a; q_b = b; q_max = mx; q_prop = pr; q_valid = 1'b1;
    @(negedge clk_i);
    q_valid = 1'b0;
    check(q_res == exp_r, req, q_res, exp_r);
    check(q_inv == exp_i, {req, " flag"}, 128'(q_inv), 128'(exp_i));
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(!s_vo && s_res == '0 && !s_inv, "R1 small", 128'(s_res), 128'(0));
    check(!q_vo && q_res == '0 && !q_inv, "R1 quad", q_res, 128'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // exhaustive sweep of the small format, all modes (R3 R4 R5 R6 R7 R8 R9 R10)
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          logic [5:0] va, vb, exp_r;
          bit an, bn, mx, pr, exp_i;
          va = 6'(a); vb = 6'(b);
          mx = m[0]; pr = m[1];
          an = s_is_nan(va); bn = s_is_nan(vb);
          exp_i = (an && !va[1]) || (bn && !vb[1]);
          if (pr ? (an || bn) : (an && bn)) exp_r = S_CANON;
          else if (an) exp_r = vb;
          else if (bn) exp_r = va;
          else if (mx) exp_r = (order_key(va) >= order_key(vb)) ? va : vb;
          else         exp_r = (order_key(va) <= order_key(vb)) ? va : vb;
          s_a = va; s_b = vb; s_max = mx; s_prop = pr; s_valid = 1'b1;
          @(negedge clk_i);
          check(s_vo, "R2 valid", 128'(s_vo), 128'(1));
          check(s_res == exp_r, pr ? "R8/R6 sweep" : (mx ? "R4 sweep" : "R3 sweep"), 128'(s_res), 128'(exp_r));
          check(s_inv == exp_i, "R9 sweep", 128'(s_inv), 128'(exp_i));
        end
      end
    end

    // R2 hold: idle cycle with new operands must not disturb outputs
    s_a = 6'b100000; s_b = 6'b000000; s_max = 1'b0; s_prop = 1'b0; s_valid = 1'b1;
    @(negedge clk_i);
    s_a = 6'b011101; s_b = 6'b011101; s_valid = 1'b0;
    @(negedge clk_i);
    check(!s_vo, "R2 idle valid", 128'(s_vo), 128'(0));
    check(s_res == 6'b100000, "R2 hold result", 128'(s_res), 128'(6'b100000));
    check(!s_inv, "R2 hold flag", 128'(s_inv), 128'(0));

    // full-width directed cases
    q_run(Q_NZERO, '0, 1'b0, 1'b0, Q_NZERO, 1'b0, "R5 min zeros");
    q_run('0, Q_NZERO, 1'b1, 1'b0, '0, 1'b0, "R5 max zeros");
    q_run(Q_ONE, Q_TWO_N, 1'b0, 1'b0, Q_TWO_N, 1'b0, "R3 quad min");
    q_run(Q_ODD, Q_ONE, 1'b1, 1'b0, Q_ODD, 1'b0, "R4 quad exact");
    q_run(Q_ONE, Q_SNAN, 1'b1, 1'b0, Q_ONE, 1'b1, "R9 snan number");
    q_run(Q_QNANP, Q_ODD, 1'b0, 1'b0, Q_ODD, 1'b0, "R6 quad");
    q_run(Q_QNANP, Q_SNAN, 1'b0, 1'b0, Q_CANON, 1'b1, "R7 quad");
    q_run(Q_ONE, Q_QNANP, 1'b1, 1'b1, Q_CANON, 1'b0, "R8 quad");
    q_run(Q_ODD, Q_ONE, 1'b0, 1'b1, Q_ONE, 1'b0, "R10 prop numbers");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule